// File: doc/BRIEF.md
# Timer Compare/Capture Output Controller

This block is one channel of an 8-bit timer. It holds a free-running up-counter and two constant registers, A and B. Each count tick compares the counter against both registers. A match on either register can act on a single timer output pin. For each register, a 2-bit action code picks what the match does to the pin: leave it alone, force it low, force it high, or invert it. Each match also raises a sticky status flag.

A capture-enable control bit gives register B a second role. When the bit is set, register B stops comparing. Its 2-bit code then picks which edge of an external capture input copies the counter into register B: rising, falling, or both. Register A compares in either role. The capture input passes through a two-stage synchronizer before any edge is detected.

Software loads the counter, the two registers and the control word, and clears flags, through a one-cycle write strobe with a small select field.

Top module: `tmr8cc_top`

## Requirements
- R1: On a cycle with `cnt_tick` high, the counter rises by one and wraps from 255 to 0. A write with `wr_sel`=0 loads `wr_data` into the counter instead.
- R2: A match A event occurs when `cnt_tick` is high and the counter equals register A (loaded with `wr_sel`=1). At the next edge the pin follows the A code (control bits [2:1]): 00 no change, 01 drive 0, 10 drive 1, 11 invert.
- R3: Flags `flag_a`, `flag_b` and `flag_cap` are set by their events and stay set. A write with `wr_sel`=4 clears each flag whose bit in `wr_data` is 1 (bit 0 for A, bit 1 for B, bit 2 for capture). An event in the same cycle as the clear wins.
- R4: When match A and match B act in the same cycle, the higher-priority action applies: invert beats drive 1, drive 1 beats drive 0, and drive 0 beats no change.
- R5: When all four code bits (control bits [4:1]) are 0, the pin is 0 at the next edge and ignores every match.
- R6: With capture disabled (control bit 0 = 0), a match B event (counter equals register B, loaded with `wr_sel`=2) applies the B code (control bits [4:3]), which uses the same encoding as the A code.
- R7: With capture enabled, the B code selects the capture edge: 00 rising, 01 falling, 1x both. The selected edge on `cap_in`, after two synchronizer stages, copies the counter into register B and sets `flag_cap`. The copy lands on the third rising clock edge after `cap_in` changes. An edge that is not selected leaves register B unchanged.
- R8: With capture enabled, a counter equal to register B neither changes the pin nor sets `flag_b`. Match A still acts.
- R9: After reset, the counter, both registers, the control word, all flags and the pin are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count enable for the current cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 counter, 1 register A, 2 register B, 3 control, 4 flag clear |
| wr_data | input | W | Write data. Control layout: [0] capture enable, [2:1] A code, [4:3] B code |
| cap_in | input | 1 | Asynchronous capture input |
| cnt_o | output | W | Counter value |
| regb_o | output | W | Register B value |
| flag_a | output | 1 | Sticky match A flag |
| flag_b | output | 1 | Sticky match B flag (compare role only) |
| flag_cap | output | 1 | Sticky capture flag |
| tmr_out | output | 1 | Timer output pin |

## Verification
The bench runs a cycle-by-cycle reference model and tries the A code alone with drive-high, drive-low and repeated inverts. These patterns show whether each code is decoded to its own action and whether an invert reads the current pin level.

Equal A and B registers with conflicting codes check the priority rule: drive 0 against drive 1 shows whether the resolver ranks by action, and invert against drive 1 shows whether invert ranks highest. A separate test uses only the B code, to confirm that B is decoded independently.

The capture tests hold the counter still and give it a different value before each edge. They walk through rising, falling and both-edge selection, plus one edge that is not selected. This separates a correct edge filter from one that captures on any transition.

A final pattern in capture role passes the counter through register B's value. It confirms that B then drives neither the pin nor its flag.

// File: rtl/tmr8cc_pkg.sv
package tmr8cc_pkg;

    // Write targets decoded from wr_sel
    typedef enum logic [2:0] {
        SEL_CNT = 3'd0,
        SEL_RA  = 3'd1,
        SEL_RB  = 3'd2,
        SEL_CTL = 3'd3,
        SEL_CLR = 3'd4
    } wsel_e;

    // Pin action codes; numeric order equals priority order
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_INV  = 2'b11
    } act_e;

    // Control word bit positions
    localparam int CTL_CAP   = 0;
    localparam int CTL_A_LSB = 1;
    localparam int CTL_B_LSB = 3;

    // Flag-clear bit positions
    localparam int CLR_A   = 0;
    localparam int CLR_B   = 1;
    localparam int CLR_CAP = 2;

endpackage

// File: rtl/tmr8cc_edge.sv
module tmr8cc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sh_d, sh_q;
    logic              last_d, last_q;

    assign sh_d[0] = din;
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        assign sh_d[i] = sh_q[i-1];
    end

    assign last_d = sh_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            last_q <= last_d;
        end
    end

    assign rise = sh_q[STAGES-1] & ~last_q;
    assign fall = ~sh_q[STAGES-1] & last_q;

endmodule

// File: rtl/tmr8cc_act.sv
module tmr8cc_act
    import tmr8cc_pkg::*;
(
    input  logic       en,
    input  logic [1:0] sel_a,
    input  logic [1:0] sel_b,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       cur,
    output logic       nxt
);

    logic [1:0] code_a, code_b, win;

    always_comb begin
        code_a = hit_a ? sel_a : ACT_HOLD;
        code_b = hit_b ? sel_b : ACT_HOLD;
        // encoding order doubles as priority: pick the larger code
        win    = (code_a > code_b) ? code_a : code_b;
        if (!en) begin
            nxt = 1'b0;
        end else begin
            case (act_e'(win))
                ACT_LOW:  nxt = 1'b0;
                ACT_HIGH: nxt = 1'b1;
                ACT_INV:  nxt = ~cur;
                default:  nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/tmr8cc_top.sv
module tmr8cc_top
    import tmr8cc_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_tick,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         cap_in,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] regb_o,
    output logic         flag_a,
    output logic         flag_b,
    output logic         flag_cap,
    output logic         tmr_out
);

    localparam logic [W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic         cap_en;
        logic [1:0]   sel_a;
        logic [1:0]   sel_b;
        logic         fa;
        logic         fb;
        logic         fc;
        logic         out;
    } st_t;

    st_t  s_d, s_q;
    logic wr_cnt, wr_ra, wr_rb, wr_ctl, wr_clr;
    logic hit_a, hit_b, out_en, rise, fall, cap_ev, out_nxt;

    assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
    assign wr_ra  = wr_en && (wr_sel == SEL_RA);
    assign wr_rb  = wr_en && (wr_sel == SEL_RB);
    assign wr_ctl = wr_en && (wr_sel == SEL_CTL);
    assign wr_clr = wr_en && (wr_sel == SEL_CLR);

    assign hit_a  = cnt_tick && (s_q.cnt == s_q.ra);
    assign hit_b  = cnt_tick && !s_q.cap_en && (s_q.cnt == s_q.rb);
    assign out_en = |{s_q.sel_a, s_q.sel_b};

    tmr8cc_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_in),
        .rise (rise),
        .fall (fall)
    );

    assign cap_ev = s_q.cap_en && (
        ((s_q.sel_b == 2'b00) && rise) ||
        ((s_q.sel_b == 2'b01) && fall) ||
        (s_q.sel_b[1] && (rise || fall)));

    tmr8cc_act u_act (
        .en   (out_en),
        .sel_a(s_q.sel_a),
        .sel_b(s_q.sel_b),
        .hit_a(hit_a),
        .hit_b(hit_b),
        .cur  (s_q.out),
        .nxt  (out_nxt)
    );

    always_comb begin
        s_d = s_q;
        if (wr_cnt)
            s_d.cnt = wr_data;
        else if (cnt_tick)
            s_d.cnt = s_q.cnt + 1'b1;
        if (wr_ra)
            s_d.ra = wr_data;
        if (cap_ev)
            s_d.rb = s_q.cnt;
        else if (wr_rb)
            s_d.rb = wr_data;
        if (wr_ctl) begin
            s_d.cap_en = wr_data[CTL_CAP];
            s_d.sel_a  = wr_data[CTL_A_LSB +: 2];
            s_d.sel_b  = wr_data[CTL_B_LSB +: 2];
        end
        if (wr_clr) begin
            if (wr_data[CLR_A])   s_d.fa = 1'b0;
            if (wr_data[CLR_B])   s_d.fb = 1'b0;
            if (wr_data[CLR_CAP]) s_d.fc = 1'b0;
        end
        if (hit_a)  s_d.fa = 1'b1;
        if (hit_b)  s_d.fb = 1'b1;
        if (cap_ev) s_d.fc = 1'b1;
        s_d.out = out_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o    = s_q.cnt;
    assign regb_o   = s_q.rb;
    assign flag_a   = s_q.fa;
    assign flag_b   = s_q.fb;
    assign flag_cap = s_q.fc;
    assign tmr_out  = s_q.out;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wr_cnt && s_q.cnt == CNT_TOP) |=> (s_q.cnt == '0)); // R1

    AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fa && !(wr_clr && wr_data[CLR_A])) |=> s_q.fa); // R3

    AST_PRIO_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && hit_a && hit_b && (s_q.sel_a == ACT_INV || s_q.sel_b == ACT_INV))
        |=> (s_q.out != $past(s_q.out))); // R4

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !s_q.out); // R5

    AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (s_q.rb == $past(s_q.cnt) && s_q.fc)); // R7

    AST_CAP_NO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cap_en && !hit_a) |=> (s_q.out == $past(s_q.out) || !s_q.out)); // R8

endmodule

// File: tb/sim_tmr8cc_top.sv
module sim_tmr8cc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cap_in = 1'b0;
    logic [7:0] cnt_o, regb_o;
    logic       flag_a, flag_b, flag_cap, tmr_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit run = 0;

    always #10 clk = ~clk;   // 50 MHz

    tmr8cc_top u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cap_in(cap_in),
        .cnt_o(cnt_o), .regb_o(regb_o), .flag_a(flag_a), .flag_b(flag_b),
        .flag_cap(flag_cap), .tmr_out(tmr_out)
    );

    // ---------------- reference model ----------------
    int m_cnt, m_a, m_b, m_cap, m_sa, m_sb, m_fa, m_fb, m_fc, m_out;
    int m_sync[$];   // synchronizer history of cap_in
    int m_last;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_a = 0; m_b = 0; m_cap = 0; m_sa = 0; m_sb = 0;
            m_fa = 0; m_fb = 0; m_fc = 0; m_out = 0; m_last = 0;
            m_sync = '{0, 0};
        end else begin
            int ha, hb, ca, cb, code, ev, seen, o_cnt;
            ha = (cnt_tick && m_cnt == m_a);
            hb = (cnt_tick && !m_cap && m_cnt == m_b);
            seen = m_sync[1];
            ev = 0;
            if (m_cap) begin
                if (m_sb == 0 && seen == 1 && m_last == 0) ev = 1;
                if (m_sb == 1 && seen == 0 && m_last == 1) ev = 1;
                if (m_sb >= 2 && seen != m_last) ev = 1;
            end
            ca = ha ? m_sa : 0;
            cb = hb ? m_sb : 0;
            code = (ca > cb) ? ca : cb;
            if (m_sa == 0 && m_sb == 0) m_out = 0;
            else if (code == 1) m_out = 0;
            else if (code == 2) m_out = 1;
            else if (code == 3) m_out = 1 - m_out;
            o_cnt = m_cnt;
            if (wr_en && wr_sel == 0) m_cnt = wr_data;
            else if (cnt_tick) m_cnt = (m_cnt + 1) % 256;
            if (wr_en && wr_sel == 1) m_a = wr_data;
            if (ev) m_b = o_cnt;
            else if (wr_en && wr_sel == 2) m_b = wr_data;
            if (wr_en && wr_sel == 4) begin
                if (wr_data[0]) m_fa = 0;
                if (wr_data[1]) m_fb = 0;
                if (wr_data[2]) m_fc = 0;
            end
            if (ha) m_fa = 1;
            if (hb) m_fb = 1;
            if (ev) m_fc = 1;
            if (wr_en && wr_sel == 3) begin
                m_cap = wr_data[0];
                m_sa = wr_data[2:1];
                m_sb = wr_data[4:3];
            end
            m_last = seen;
            m_sync.push_front(int'(cap_in));
            void'(m_sync.pop_back());
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every cycle, away from the active edge
    always @(negedge clk) if (run) begin
        chk("R1 counter", cnt_o, m_cnt);
        chk("R2 pin", tmr_out, m_out);
        chk("R3 flag_a", flag_a, m_fa);
        chk("R3 flag_b", flag_b, m_fb);
        chk("R7 flag_cap", flag_cap, m_fc);
        chk("R7 regb", regb_o, m_b);
    end

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_tick = 1;
        repeat (n) @(negedge clk);
        cnt_tick = 0;
    endtask

    function automatic int ctl(int cap, int a, int b);
        return cap | (a << 1) | (b << 3);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic held;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 cnt", cnt_o, 0); chk("R9 regb", regb_o, 0);
        chk("R9 flags", {flag_a, flag_b, flag_cap}, 0); chk("R9 pin", tmr_out, 0);
        rst_n = 1;
        run = 1;

        // R1: counting and wrap
        wr(0, 250);
        ticks(6);
        chk("R1 wrap", cnt_o, 0);
        ticks(300);
        chk("R1 free run", cnt_o, 44);

        // R2: A codes
        wr(1, 5);
        wr(3, ctl(0, 2, 0));
        wr(0, 0); ticks(6);
        chk("R2 drive1", tmr_out, 1);
        chk("R2 flag_a", flag_a, 1);
        wr(3, ctl(0, 1, 0));
        wr(0, 0); ticks(6);
        chk("R2 drive0", tmr_out, 0);
        wr(3, ctl(0, 3, 0));
        wr(0, 0); ticks(6);
        chk("R2 invert1", tmr_out, 1);
        wr(0, 0); ticks(6);
        chk("R2 invert2", tmr_out, 0);

        // R3: write-1 clear
        wr(4, 1);
        chk("R3 clear a", flag_a, 0);
        wr(4, 2);
        chk("R3 clear b", flag_b, 0);

        // R4: priority with A == B
        wr(1, 20); wr(2, 20);
        wr(3, ctl(0, 1, 2));
        wr(0, 15); ticks(6);
        chk("R4 high over low", tmr_out, 1);
        wr(3, ctl(0, 3, 2));
        wr(0, 15); ticks(6);
        chk("R4 invert over high", tmr_out, 0);

        // R6: B code alone
        wr(3, ctl(0, 0, 3));
        wr(0, 15); ticks(6);
        chk("R6 B invert", tmr_out, 1);
        chk("R6 flag_b", flag_b, 1);

        // R5: output disabled
        wr(3, ctl(0, 0, 0));
        @(negedge clk);
        chk("R5 forced low", tmr_out, 0);
        wr(0, 15); ticks(6);
        chk("R5 ignores match", tmr_out, 0);

        // R7: capture edges with the counter held
        wr(3, ctl(1, 0, 0));
        wr(0, 77);
        cap_in = 1; repeat (5) @(negedge clk);
        chk("R7 rising copy", regb_o, 77);
        chk("R7 flag_cap", flag_cap, 1);
        wr(3, ctl(1, 0, 1));
        wr(0, 90);
        cap_in = 0; repeat (5) @(negedge clk);
        chk("R7 falling copy", regb_o, 90);
        wr(0, 33);
        cap_in = 1; repeat (5) @(negedge clk);
        chk("R7 unselected edge", regb_o, 90);
        wr(3, ctl(1, 0, 2));
        wr(0, 44);
        cap_in = 0; repeat (5) @(negedge clk);
        chk("R7 both edges", regb_o, 44);

        // R8: capture role, counter passes register B
        wr(1, 200);
        wr(4, 7);
        held = tmr_out;
        wr(0, 40); ticks(10);
        chk("R8 pin unchanged", tmr_out, held);
        chk("R8 no flag_b", flag_b, 0);
        wr(1, 60);
        wr(3, ctl(1, 2, 2));
        wr(0, 55); ticks(8);
        chk("R8 A still acts", tmr_out, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule